// File: doc/BRIEF.md
# Rename Stage Stall and Skid Controller

This block is the control machine of one thread in a register-rename pipeline stage. Each cycle it decides where the instruction handed to rename comes from: the live stream from decode, or a small skid store that holds instructions caught in flight while the stage was stalled. It also tells decode when to stop and when to start sending again.

Stall causes come from outside. A downstream resource-full request forces a block. A serialize request holds the instruction at the head of the current source until the pipeline has drained. The serialize hold is never replaced by a plain block, so it can always finish. The stop and resume indications to decode are registered single-cycle pulses. The controller raises a stop only when decode does not already consider the stage stopped.

The skid store is a FIFO of instruction tags whose depth is a parameter. A push into a full store with no pop in the same cycle drops the tag and sets a sticky error flag.

Top module: `rename_stall_ctrl`

## Requirements
- R1: During and after reset, until the first input arrives, `state_o` reads Idle (1), and `out_valid_o`, `block_up_o`, `unblock_up_o` and `overflow_o` are low. State codes: Running=0, Idle=1, Blocked=2, Unblocking=3, SerialStall=4.
- R2: In Running or Idle, with `stall_i` and `ser_req_i` low, `out_valid_o`/`out_tag_o` equal `in_valid_i`/`in_tag_i` in the same cycle. The next state is Running if the input was valid, otherwise Idle.
- R3: In Running or Idle, `stall_i` suppresses output and places a valid input at the skid tail. The state becomes Blocked, and `block_up_o` pulses for one cycle after that edge.
- R4: In Blocked, nothing is output and valid inputs are appended to the skid store. The state moves to Unblocking in the first cycle that `stall_i` is low.
- R5: In Unblocking, with no stall or serialize request, the skid head is output, one per cycle in arrival order, and a valid input is appended behind the skid contents.
- R6: When an Unblocking cycle leaves the skid store empty and has no valid input, the state becomes Running and `unblock_up_o` pulses for one cycle after that edge.
- R7: `stall_i` in Unblocking moves to Blocked and sends `block_up_o` only when `resume_i` was high in that cycle.
- R8: `ser_req_i` with a head instruction present (a valid input in Running/Idle, or a non-empty skid store in Unblocking) outputs nothing, keeps the head, and enters SerialStall. From Running/Idle, `block_up_o` is sent. From Unblocking, it is sent only with `resume_i`.
- R9: SerialStall persists until `ser_done_i`, even under `stall_i`. Valid inputs go to the skid store, and `stall_i` there produces a `block_up_o` pulse.
- R10: `ser_done_i` in SerialStall moves to Unblocking, or to Blocked if `stall_i` is also high.
- R11: A push into a full skid store with no pop in the same cycle discards the tag. `overflow_o` then rises after that edge and stays high until reset.
- R12: `block_up_o` and `unblock_up_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction from decode is present |
| in_tag_i | input | TAG_W | Tag of the decode instruction |
| stall_i | input | 1 | Downstream resource-full block request |
| ser_req_i | input | 1 | Head instruction must serialize |
| ser_done_i | input | 1 | Serialize condition satisfied |
| resume_i | input | 1 | Resume-unblocking flag; permits stop while Unblocking |
| out_valid_o | output | 1 | Instruction handed to rename this cycle |
| out_tag_o | output | TAG_W | Tag of the handed instruction |
| state_o | output | 3 | Current state code |
| block_up_o | output | 1 | Registered stop pulse to decode |
| unblock_up_o | output | 1 | Registered resume pulse to decode |
| overflow_o | output | 1 | Sticky skid overflow error |

## Verification
A wrong state shows up on `state_o` one edge after the faulty transition. It then shows in the source of the very next output: a tag taken from decode where a skid tag was due, or the reverse, appears on `out_tag_o` in the same cycle. A lost or duplicated skid entry stays hidden until the drain. It then shows as a tag out of order, or as an `unblock_up_o` pulse one cycle early or late. Comparing every cycle against a queue model catches each of these at the first cycle it becomes visible.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_IDLE    = 3'd1,
    ST_BLOCKED = 3'd2,
    ST_UNBLK   = 3'd3,
    ST_SER     = 3'd4
  } rsc_state_e;

  typedef struct packed {
    logic emit;
    logic from_skid;
    logic push;
    logic pop;
    logic blk;
    logic unblk;
  } rsc_ctl_t;
endpackage

// File: rtl/rsc_skid_fifo.sv
module rsc_skid_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         one_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] cnt;
  logic             do_pop;

  assign do_pop  = pop_i && !empty_o;
  assign empty_o = (cnt == '0);
  assign one_o   = (cnt == CNT_W'(1));
  assign full_o  = (cnt == FULL_CNT);
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
      if (do_pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
      if (push_i && !do_pop)      cnt <= cnt + CNT_W'(1);
      else if (!push_i && do_pop) cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= din_i;
  end
endmodule

// File: rtl/rsc_ctrl.sv
module rsc_ctrl
  import rsc_pkg::*;
(
  input  rsc_state_e state_i,
  input  logic       in_valid_i,
  input  logic       stall_i,
  input  logic       ser_req_i,
  input  logic       ser_done_i,
  input  logic       resume_i,
  input  logic       skid_empty_i,
  input  logic       skid_one_i,
  output rsc_ctl_t   ctl_o,
  output rsc_state_e next_o
);
  always_comb begin
    ctl_o  = '0;
    next_o = state_i;
    unique case (state_i)
      ST_RUN, ST_IDLE: begin
        if (stall_i) begin
          ctl_o.push = in_valid_i;
          ctl_o.blk  = 1'b1;
          next_o     = ST_BLOCKED;
        end else if (ser_req_i && in_valid_i) begin
          ctl_o.push = 1'b1;
          ctl_o.blk  = 1'b1;
          next_o     = ST_SER;
        end else begin
          ctl_o.emit = in_valid_i;
          next_o     = in_valid_i ? ST_RUN : ST_IDLE;
        end
      end
      ST_BLOCKED: begin
        ctl_o.push = in_valid_i;
        if (!stall_i) next_o = ST_UNBLK;
      end
      ST_UNBLK: begin
        if (stall_i) begin
          ctl_o.push = in_valid_i;
          ctl_o.blk  = resume_i;   // decode already thinks we are stopped otherwise
          next_o     = ST_BLOCKED;
        end else if (ser_req_i && !skid_empty_i) begin
          ctl_o.push = in_valid_i;
          ctl_o.blk  = resume_i;
          next_o     = ST_SER;
        end else begin
          ctl_o.emit      = !skid_empty_i;
          ctl_o.from_skid = 1'b1;
          ctl_o.pop       = !skid_empty_i;
          ctl_o.push      = in_valid_i;
          if (!in_valid_i && (skid_empty_i || skid_one_i)) begin
            ctl_o.unblk = 1'b1;
            next_o      = ST_RUN;
          end
        end
      end
      ST_SER: begin
        ctl_o.push = in_valid_i;
        ctl_o.blk  = stall_i;
        if (ser_done_i) next_o = stall_i ? ST_BLOCKED : ST_UNBLK;
      end
      default: next_o = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/rsc_upsig.sv
module rsc_upsig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic blk_i,
  input  logic unblk_i,
  input  logic ovf_set_i,
  output logic block_up_o,
  output logic unblock_up_o,
  output logic overflow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      block_up_o   <= 1'b0;
      unblock_up_o <= 1'b0;
      overflow_o   <= 1'b0;
    end else begin
      block_up_o   <= blk_i;
      unblock_up_o <= unblk_i && !blk_i;
      if (ovf_set_i) overflow_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rename_stall_ctrl.sv
module rename_stall_ctrl
  import rsc_pkg::*;
#(
  parameter int TAG_W      = 8,
  parameter int SKID_DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [TAG_W-1:0] in_tag_i,
  input  logic             stall_i,
  input  logic             ser_req_i,
  input  logic             ser_done_i,
  input  logic             resume_i,
  output logic             out_valid_o,
  output logic [TAG_W-1:0] out_tag_o,
  output logic [2:0]       state_o,
  output logic             block_up_o,
  output logic             unblock_up_o,
  output logic             overflow_o
);
  rsc_state_e       state_q, state_d;
  rsc_ctl_t         ctl;
  logic             skid_empty, skid_one, skid_full;
  logic             push_ok, ovf_set;
  logic [TAG_W-1:0] skid_head;

  rsc_ctrl u_ctrl (
    .state_i     (state_q),
    .in_valid_i  (in_valid_i),
    .stall_i     (stall_i),
    .ser_req_i   (ser_req_i),
    .ser_done_i  (ser_done_i),
    .resume_i    (resume_i),
    .skid_empty_i(skid_empty),
    .skid_one_i  (skid_one),
    .ctl_o       (ctl),
    .next_o      (state_d)
  );

  // full store accepts a push only when the same cycle frees a slot
  assign ovf_set = ctl.push && skid_full && !ctl.pop;
  assign push_ok = ctl.push && !ovf_set;

  rsc_skid_fifo #(.DEPTH(SKID_DEPTH), .W(TAG_W)) u_skid (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push_ok),
    .pop_i  (ctl.pop),
    .din_i  (in_tag_i),
    .head_o (skid_head),
    .empty_o(skid_empty),
    .one_o  (skid_one),
    .full_o (skid_full)
  );

  rsc_upsig u_upsig (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .blk_i       (ctl.blk),
    .unblk_i     (ctl.unblk),
    .ovf_set_i   (ovf_set),
    .block_up_o  (block_up_o),
    .unblock_up_o(unblock_up_o),
    .overflow_o  (overflow_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign out_valid_o = ctl.emit;
  assign out_tag_o   = ctl.from_skid ? skid_head : in_tag_i;
  assign state_o     = state_q;
endmodule

// File: rtl/rename_stall_ctrl_chk.sv
module rename_stall_ctrl_chk #(
  parameter int TAG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic [TAG_W-1:0] in_tag_i,
  input logic             stall_i,
  input logic             ser_req_i,
  input logic             ser_done_i,
  input logic             out_valid_o,
  input logic [TAG_W-1:0] out_tag_o,
  input logic [2:0]       state_o,
  input logic             block_up_o,
  input logic             unblock_up_o,
  input logic             overflow_o
);
  a_r12_up_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(block_up_o && unblock_up_o));

  a_r11_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  a_r9_ser_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && !ser_done_i) |=> (state_o == 3'd4));

  a_r4_blocked_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2) |-> !out_valid_o);

  a_r6_unblock_to_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unblock_up_o |-> (state_o == 3'd0));

  a_r2_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o == 3'd0 || state_o == 3'd1) && !stall_i && !ser_req_i && in_valid_i)
      |-> (out_valid_o && out_tag_o == in_tag_i));

  a_r3_block_from_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o == 3'd0 || state_o == 3'd1) && stall_i) |=> (state_o == 3'd2 && block_up_o));
endmodule

bind rename_stall_ctrl rename_stall_ctrl_chk #(.TAG_W(TAG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_tag_i    (in_tag_i),
  .stall_i     (stall_i),
  .ser_req_i   (ser_req_i),
  .ser_done_i  (ser_done_i),
  .out_valid_o (out_valid_o),
  .out_tag_o   (out_tag_o),
  .state_o     (state_o),
  .block_up_o  (block_up_o),
  .unblock_up_o(unblock_up_o),
  .overflow_o  (overflow_o)
);

// File: tb/rename_stall_ctrl_bench.sv
`timescale 1ns/1ps
module rename_stall_ctrl_bench;
  localparam int TAG_W = 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid_i = 1'b0, stall_i = 1'b0, ser_req_i = 1'b0, ser_done_i = 1'b0, resume_i = 1'b0;
  logic [TAG_W-1:0] in_tag_i = '0;
  logic out_valid_o, block_up_o, unblock_up_o, overflow_o;
  logic [TAG_W-1:0] out_tag_o;
  logic [2:0] state_o;

  int checks = 0, failures = 0;
  bit finished = 0;

  // reference model
  int m_st = 1;
  int q[$];
  bit m_blk = 0, m_unblk = 0, m_ovf = 0;

  always #4 clk = ~clk;

  rename_stall_ctrl #(.TAG_W(TAG_W), .SKID_DEPTH(DEPTH)) u_rename_stall_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_tag_i(in_tag_i),
    .stall_i(stall_i), .ser_req_i(ser_req_i), .ser_done_i(ser_done_i), .resume_i(resume_i),
    .out_valid_o(out_valid_o), .out_tag_o(out_tag_o), .state_o(state_o),
    .block_up_o(block_up_o), .unblock_up_o(unblock_up_o), .overflow_o(overflow_o));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic mpush(input int t);
    if (q.size() == DEPTH) m_ovf = 1;
    else q.push_back(t);
  endtask

  task automatic step(input bit v, input int t, input bit st, input bit ser,
                      input bit done, input bit res, input string req);
    bit e_v, blk, unblk;
    int e_t, nst;
    @(negedge clk);
    in_valid_i = v; in_tag_i = TAG_W'(t); stall_i = st;
    ser_req_i = ser; ser_done_i = done; resume_i = res;
    #1;
    chk(req, "state", state_o, m_st);
    chk(req, "block_up", block_up_o, m_blk);
    chk(req, "unblock_up", unblock_up_o, m_unblk);
    chk(req, "overflow", overflow_o, m_ovf);
    chk("R12", "up_both", block_up_o && unblock_up_o, 0);
    e_v = 0; e_t = 0; blk = 0; unblk = 0; nst = m_st;
    case (m_st)
      0, 1: begin
        if (st) begin if (v) mpush(t); blk = 1; nst = 2; end
        else if (ser && v) begin mpush(t); blk = 1; nst = 4; end
        else begin e_v = v; e_t = t; nst = v ? 0 : 1; end
      end
      2: begin if (v) mpush(t); if (!st) nst = 3; end
      3: begin
        if (st) begin if (v) mpush(t); blk = res; nst = 2; end
        else if (ser && q.size() > 0) begin if (v) mpush(t); blk = res; nst = 4; end
        else begin
          if (q.size() > 0) begin e_v = 1; e_t = q.pop_front(); end
          if (v) mpush(t);
          if (q.size() == 0) begin unblk = 1; nst = 0; end
        end
      end
      default: begin
        if (v) mpush(t);
        blk = st;
        if (done) nst = st ? 2 : 3;
      end
    endcase
    chk(req, "out_valid", out_valid_o, e_v);
    if (e_v) chk(req, "out_tag", out_tag_o, e_t);
    @(posedge clk);
    m_st = nst; m_blk = blk; m_unblk = unblk;
  endtask

  initial begin
    #20;
    chk("R1", "state_rst", state_o, 1);
    chk("R1", "outs_rst", {out_valid_o, block_up_o, unblock_up_o, overflow_o}, 0);
    @(negedge clk); rst_ni = 1'b1;
    step(0, 0, 0, 0, 0, 0, "R1");
    // pass-through
    for (int i = 1; i <= 3; i++) step(1, i, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 1, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, "R2");
    // block, hold, drain
    step(1, 10, 1, 0, 0, 0, "R3");
    step(1, 11, 1, 0, 0, 0, "R4");
    step(1, 12, 1, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, "R4");
    step(1, 13, 0, 0, 0, 0, "R5");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, "R6");
    // stall while unblocking, with and without resume flag
    step(1, 30, 1, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 0, "R4");
    step(1, 31, 1, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 1, 0, 0, 1, "R7");
    step(0, 0, 0, 0, 0, 0, "R7");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, "R6");
    // serialize from running
    step(1, 40, 0, 0, 0, 0, "R2");
    step(1, 41, 0, 1, 0, 0, "R8");
    step(1, 42, 1, 0, 0, 0, "R9");
    step(0, 0, 0, 1, 0, 0, "R9");
    step(1, 43, 0, 0, 1, 0, "R10");
    step(0, 0, 0, 1, 0, 1, "R8");
    step(0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 1, 0, 1, 0, "R10");
    step(0, 0, 0, 0, 0, 0, "R10");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, "R5");
    // overflow
    step(1, 50, 1, 0, 0, 0, "R3");
    for (int i = 1; i <= 5; i++) step(1, 50 + i, 1, 0, 0, 0, "R11");
    step(0, 0, 0, 0, 0, 0, "R11");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 0, "R11");
    chk("R11", "overflow_sticky", overflow_o, 1);
    for (int i = 1; i <= 3; i++) step(1, 60 + i, 0, 0, 0, 0, "R2");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule